// File: doc/BRIEF.md
# Integer condition code generator

The block turns one arithmetic or logical result into the four integer condition flags: negative, zero, overflow and carry. It writes them into a 32-bit processor status word and changes nothing else in that word. Each cycle the datapath presents the two operands, the result it computed and an operation class. It also presents the status word as it stands now. The block returns the updated status word one clock later.

Overflow and carry come from the sign bits of the operands and the result alone, so no second adder is needed. For a subtract, the carry flag holds the borrow. The flag field sits at status bits 23 down to 20. A low update enable lets the status word through untouched.

Top module: `icc_gen`

## Requirements
- R1: While rst_ni is low, psr_o is all zeros.
- R2: psr_o shows the result of the inputs sampled at a rising clock edge from that edge until the next one, which is a latency of one cycle.
- R3: Status bits 31:24 and 19:0 of psr_o equal the same bits of psr_i, whatever the operation and the enable.
- R4: When updating, bit 23 (negative) is res_i[31], and bit 22 (zero) is 1 exactly when all 32 bits of res_i are 0.
- R5: With op_class_i = 2'b00 (add), bit 21 (overflow) is bit 31 of (a & b & ~r) | (~a & ~b & r).
- R6: With op_class_i = 2'b00 (add), bit 20 (carry) is bit 31 of (a & b) | ((a | b) & ~r). For r = a + b this is the carry out of a 33-bit sum.
- R7: With op_class_i = 2'b01 (subtract), bit 21 (overflow) is bit 31 of (a & ~b & ~r) | (~a & b & r).
- R8: With op_class_i = 2'b01 (subtract), bit 20 (borrow) is bit 31 of (~a & b) | ((~a | b) & r). For r = a - b this is 1 exactly when a < b unsigned.
- R9: With op_class_i = 2'b10 (logical), bits 21 and 20 are cleared.
- R10: When upd_en_i is low, psr_o equals psr_i in full, including the flag field.
- R11: op_class_i = 2'b11 behaves exactly like the logical class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_en_i | input | 1 | Write new flags when high |
| op_class_i | input | 2 | 00 add, 01 subtract, 10 logical, 11 logical |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| res_i | input | 32 | Result computed by the datapath |
| psr_i | input | 32 | Current status word |
| psr_o | output | 32 | Updated status word, registered |

## Verification
Random operands are tried in two ways. When the result is the true sum or difference, the flags must match a 33-bit arithmetic model, which confirms that the sign-bit formulas give the real carry, borrow and overflow. When the result is unrelated to the operands, the formulas are exercised on sign combinations that real arithmetic never produces. Directed cases cover the signed overflow boundaries (0x7FFFFFFF+1 and 0x80000000-1), a wrap to zero with carry, and a borrow from zero. Further cases cover logical results that must clear stale V and C, a disabled update that carries the incoming flags through, and the reserved class code.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SUB   = 2'b01,
    OP_LOGIC = 2'b10,
    OP_RSVD  = 2'b11
  } op_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } icc_t;

  localparam int unsigned FLAG_W = 4;
endpackage

// File: rtl/icc_nz.sv
module icc_nz #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] res_i,
  output logic          n_o,
  output logic          z_o
);
  assign n_o = res_i[DW-1];
  assign z_o = ~|res_i;
endmodule

// File: rtl/icc_cv.sv
module icc_cv
  import icc_pkg::*;
(
  input  op_class_e op_i,
  input  logic      a_msb_i,
  input  logic      b_msb_i,
  input  logic      r_msb_i,
  output logic      v_o,
  output logic      c_o
);
  always_comb begin
    v_o = 1'b0;
    c_o = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        v_o = (a_msb_i & b_msb_i & ~r_msb_i) | (~a_msb_i & ~b_msb_i & r_msb_i);
        c_o = (a_msb_i & b_msb_i) | ((a_msb_i | b_msb_i) & ~r_msb_i);
      end
      OP_SUB: begin
        v_o = (a_msb_i & ~b_msb_i & ~r_msb_i) | (~a_msb_i & b_msb_i & r_msb_i);
        // borrow out of the top bit
        c_o = (~a_msb_i & b_msb_i) | ((~a_msb_i | b_msb_i) & r_msb_i);
      end
      default: begin
        v_o = 1'b0;
        c_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/icc_merge.sv
module icc_merge
  import icc_pkg::*;
#(
  parameter int unsigned SW       = 32,
  parameter int unsigned FLAG_LSB = 20
) (
  input  logic          en_i,
  input  icc_t          flags_i,
  input  logic [SW-1:0] psr_i,
  output logic [SW-1:0] psr_o
);
  localparam int unsigned FLAG_MSB = FLAG_LSB + FLAG_W - 1;

  always_comb begin
    psr_o = psr_i;
    if (en_i) psr_o[FLAG_MSB:FLAG_LSB] = flags_i;
  end
endmodule

// File: rtl/icc_gen.sv
module icc_gen
  import icc_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned SW       = 32,
  parameter int unsigned FLAG_LSB = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_en_i,
  input  logic [1:0]    op_class_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [DW-1:0] res_i,
  input  logic [SW-1:0] psr_i,
  output logic [SW-1:0] psr_o
);
  op_class_e     op;
  icc_t          flags;
  logic [SW-1:0] psr_nxt;
  logic [SW-1:0] psr_q;

  assign op = op_class_e'(op_class_i);

  icc_nz #(.DW(DW)) i_nz (
    .res_i (res_i),
    .n_o   (flags.n),
    .z_o   (flags.z)
  );

  icc_cv i_cv (
    .op_i    (op),
    .a_msb_i (opa_i[DW-1]),
    .b_msb_i (opb_i[DW-1]),
    .r_msb_i (res_i[DW-1]),
    .v_o     (flags.v),
    .c_o     (flags.c)
  );

  icc_merge #(.SW(SW), .FLAG_LSB(FLAG_LSB)) i_merge (
    .en_i    (upd_en_i),
    .flags_i (flags),
    .psr_i   (psr_i),
    .psr_o   (psr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psr_q <= '0;
    else         psr_q <= psr_nxt;
  end

  assign psr_o = psr_q;
endmodule

// File: rtl/icc_gen_chk.sv
module icc_gen_chk #(
  parameter int unsigned DW       = 32,
  parameter int unsigned SW       = 32,
  parameter int unsigned FLAG_LSB = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          upd_en_i,
  input logic [1:0]    op_class_i,
  input logic [DW-1:0] opa_i,
  input logic [DW-1:0] opb_i,
  input logic [DW-1:0] res_i,
  input logic [SW-1:0] psr_i,
  input logic [SW-1:0] psr_o
);
  localparam logic [SW-1:0] FMASK = {{(SW-4){1'b0}}, 4'hF} << FLAG_LSB;
  localparam int unsigned N_B = FLAG_LSB + 3;
  localparam int unsigned Z_B = FLAG_LSB + 2;
  localparam int unsigned V_B = FLAG_LSB + 1;
  localparam int unsigned C_B = FLAG_LSB;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_comb if (!rst_ni) AST_RESET_ZERO: assert (psr_o == '0); // R1

  AST_KEEP_OTHER_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (psr_o & ~FMASK) == ($past(psr_i) & ~FMASK)); // R3

  AST_NEG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(upd_en_i) |->
      psr_o[N_B] == $past(res_i[DW-1]) && psr_o[Z_B] == ($past(res_i) == '0)); // R4

  AST_ADD_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(upd_en_i) && $past(op_class_i) == 2'b00 &&
      $past(res_i == opa_i + opb_i) |->
      psr_o[C_B] == $past(({1'b0, opa_i} + {1'b0, opb_i}) >> DW)); // R6

  AST_SUB_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(upd_en_i) && $past(op_class_i) == 2'b01 &&
      $past(res_i == opa_i - opb_i) |->
      psr_o[C_B] == $past(opa_i < opb_i)); // R8

  AST_LOGIC_CLR_VC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(upd_en_i) && $past(op_class_i[1]) |->
      psr_o[V_B] == 1'b0 && psr_o[C_B] == 1'b0); // R9

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(upd_en_i) |-> psr_o == $past(psr_i)); // R10
endmodule

bind icc_gen icc_gen_chk #(.DW(DW), .SW(SW), .FLAG_LSB(FLAG_LSB)) i_icc_gen_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .upd_en_i   (upd_en_i),
  .op_class_i (op_class_i),
  .opa_i      (opa_i),
  .opb_i      (opb_i),
  .res_i      (res_i),
  .psr_i      (psr_i),
  .psr_o      (psr_o)
);

// File: tb/test_icc_gen.sv
module test_icc_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        upd_en_i = 1'b0;
  logic [1:0]  op_class_i = 2'b00;
  logic [31:0] opa_i = '0, opb_i = '0, res_i = '0, psr_i = '0;
  logic [31:0] psr_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  icc_gen i_icc_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_en_i(upd_en_i), .op_class_i(op_class_i),
    .opa_i(opa_i), .opb_i(opb_i), .res_i(res_i), .psr_i(psr_i), .psr_o(psr_o)
  );

  function automatic logic [31:0] exp_psr(logic en, logic [1:0] op, logic [31:0] a,
                                          logic [31:0] b, logic [31:0] r, logic [31:0] p);
    logic [31:0] q;
    logic v, c;
    q = p;
    if (!en) return q;
    unique case (op)
      2'b00: begin
        v = ((a & b & ~r) | (~a & ~b & r)) >> 31;
        c = ((a & b) | ((a | b) & ~r)) >> 31;
      end
      2'b01: begin
        v = ((a & ~b & ~r) | (~a & b & r)) >> 31;
        c = ((~a & b) | ((~a | b) & r)) >> 31;
      end
      default: begin v = 1'b0; c = 1'b0; end
    endcase
    q[23] = r[31];
    q[22] = (r == 32'h0);
    q[21] = v;
    q[20] = c;
    return q;
  endfunction

  // 33-bit arithmetic model: {n,z,v,c}
  function automatic logic [3:0] ref33(logic sub, logic [31:0] a, logic [31:0] b);
    logic [32:0] s;
    logic v;
    s = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    v = sub ? ((a[31] != b[31]) && (s[31] != a[31]))
            : ((a[31] == b[31]) && (s[31] != a[31]));
    return {s[31], s[31:0] == 32'h0, v, s[32]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic apply(logic en, logic [1:0] op, logic [31:0] a, logic [31:0] b,
                       logic [31:0] r, logic [31:0] p, string tag);
    @(negedge clk_i);
    upd_en_i = en; op_class_i = op; opa_i = a; opb_i = b; res_i = r; psr_i = p;
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag, psr_o, exp_psr(en, op, a, b, r, p));
  endtask

  task automatic arith(logic sub, logic [31:0] a, logic [31:0] b, logic [31:0] p,
                       string tag);
    logic [31:0] r;
    logic [3:0] f;
    r = sub ? a - b : a + b;
    f = ref33(sub, a, b);
    apply(1'b1, {1'b0, sub}, a, b, r, p, tag);
    check({tag, " 33bit"}, {28'h0, psr_o[23:20]}, {28'h0, f});
  endtask

  initial begin
    void'($urandom(32'h5eed_1cc0));
    psr_i = 32'hFFFF_FFFF;
    #5;
    check("R1", psr_o, 32'h0);
    @(negedge clk_i);
    check("R1", psr_o, 32'h0);
    rst_ni = 1'b1;

    // R2: new value appears right after the edge, not before
    @(negedge clk_i);
    upd_en_i = 1'b1; op_class_i = 2'b10; res_i = 32'h0; psr_i = 32'h0;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R2", psr_o, 32'h0040_0000);
    psr_i = 32'h1234_5678; upd_en_i = 1'b0;
    #5;
    check("R2", psr_o, 32'h0040_0000);

    arith(1'b0, 32'h7FFF_FFFF, 32'h1, 32'h0, "R4 R5 R6 max plus one");
    check("R5", {31'h0, psr_o[21]}, 32'h1);
    arith(1'b1, 32'h8000_0000, 32'h1, 32'hA5A5_A5A5, "R3 R7 R8 min minus one");
    check("R7", {31'h0, psr_o[21]}, 32'h1);
    arith(1'b0, 32'hFFFF_FFFF, 32'h1, 32'h0, "R4 R6 wrap to zero");
    check("R6", {28'h0, psr_o[23:20]}, 32'h5);
    arith(1'b1, 32'h0, 32'h1, 32'h0, "R8 borrow from zero");
    check("R8", {28'h0, psr_o[23:20]}, 32'h9);
    arith(1'b1, 32'h5, 32'h5, 32'h0, "R4 R8 equal operands");
    check("R4", {28'h0, psr_o[23:20]}, 32'h4);

    apply(1'b1, 2'b10, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0030_0000, "R9 logical zero");
    check("R9", {28'h0, psr_o[23:20]}, 32'h4);
    apply(1'b1, 2'b10, 32'h0, 32'h0, 32'h8000_0001, 32'hFFFF_FFFF, "R3 R9 logical neg");
    check("R9", psr_o, 32'hFF8F_FFFF);
    apply(1'b1, 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0030_0000, "R11 reserved class");
    check("R11", psr_o, 32'h0040_0000);
    apply(1'b0, 2'b00, 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h00A0_0F0F, "R10 update off");
    check("R10", psr_o, 32'h00A0_0F0F);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b, p;
      logic sub;
      a = $urandom(); b = $urandom(); p = $urandom(); sub = 1'($urandom());
      if (i % 7 == 0) b = a;
      arith(sub, a, b, p, sub ? "R3 R4 R7 R8 random sub" : "R3 R4 R5 R6 random add");
    end
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b, r, p;
      logic [1:0] op;
      logic en;
      a = $urandom(); b = $urandom(); r = $urandom(); p = $urandom();
      op = 2'($urandom()); en = ($urandom() % 4) != 0;
      if (i % 9 == 0) r = 32'h0;
      apply(en, op, a, b, r, p, "R3 R4 R5 R6 R7 R8 R9 R10 R11 free result");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule